// File: doc/BRIEF.md
# Timer Compare Waveform Generator

An 8-bit timer with two compare channels, A and B, each driving one output pad. The counter advances on each cycle where the count-enable strobe is high. It runs in one of four counting families. The plain free-running family and the clear-on-match family form the non-PWM group. The single-slope family gives fast PWM, and the dual-slope family gives phase-correct PWM. The TOP value is either the all-ones count or the active compare A value.

Each channel has a 2-bit output mode. Together with the counting family, this mode decides how the channel's waveform bit reacts to compare hits and to the counter reaching TOP or BOTTOM. A pad shows the waveform bit when its channel is connected and shows the port-data bit otherwise. The pad's enable always follows the channel's direction bit.

Compare values are double-buffered in the PWM families. In the non-PWM families they take effect at once. A compare write that lands on the value the counter holds blocks the compare hit on the next counting cycle.

Top module: `tmr_wave_unit`

## Requirements
- R1: After reset, the count is 0 and counting is upward. Both waveform bits are 0, both compare values are 0, and each pad shows its port-data bit.
- R2: `pad_oe_o` equals `dir_i`. A channel is connected when its mode is nonzero, except for mode 01 in a PWM family. That mode is connected only for channel A, and only when `top_sel_i` is 1. A connected pad shows the waveform bit. An unconnected pad shows `port_i`.
- R3: `wave_mode_i` selects the family: 00 free-running, 01 dual-slope, 10 clear-on-match, 11 single-slope. TOP is compare A in clear-on-match. It is also compare A in either PWM family when `top_sel_i` is 1. Otherwise TOP is 255. Free-running counts 0..255 and wraps. Clear-on-match and single-slope go from TOP to 0. Dual-slope turns down at TOP and turns up at 0.
- R4: A compare hit occurs on a counting cycle where the count equals the active compare value. In the non-PWM families, a hit toggles the waveform bit for mode 01, clears it for 10 and sets it for 11.
- R5: In single-slope, a hit clears the bit for mode 10 and sets it for 11. On the cycle the counter wraps from TOP to BOTTOM, the bit is set for 10 and cleared for 11, and this wrap action wins over a hit in the same cycle.
- R6: In dual-slope, a hit with the counter stepping up clears the bit for mode 10 and sets it for 11. A hit with the counter stepping down does the opposite. The step direction is the direction the counter leaves the hit value.
- R7: In a PWM family with mode 01, channel A toggles on each hit when `top_sel_i` is 1. Channel B with mode 01 is unconnected and its pad shows `port_i`.
- R8: In single-slope, when channel A's mode high bit is 1 and compare A equals TOP, compare A hits are ignored and only the BOTTOM action changes the bit.
- R9: In dual-slope, when channel A's mode high bit is 1 and compare A equals TOP, hits are ignored. Instead, reaching TOP sets the bit for mode 10 and clears it for 11.
- R10: In the PWM families, a compare write is held and becomes active on the counting cycle that leaves TOP. If a write arrives in that same cycle, its value is the one loaded. In the non-PWM families, a write becomes active at the next edge.
- R11: A compare write whose value equals the count after that edge suppresses that channel's hit on the next counting cycle only.
- R12: On cycles with `tick_i` low, the count, the direction and both waveform bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable (prescaled strobe) |
| wave_mode_i | input | 2 | Counting family select |
| top_sel_i | input | 1 | PWM TOP = compare A; enables channel A toggle |
| cmp_a_we_i | input | 1 | Compare A write strobe |
| cmp_a_i | input | 8 | Compare A write data |
| cmp_b_we_i | input | 1 | Compare B write strobe |
| cmp_b_i | input | 8 | Compare B write data |
| out_mode_a_i | input | 2 | Channel A output mode |
| out_mode_b_i | input | 2 | Channel B output mode |
| dir_i | input | 2 | Pad direction bits (bit 0 = A) |
| port_i | input | 2 | Port data bits (bit 0 = A) |
| pad_o | output | 2 | Pad data (bit 0 = A) |
| pad_oe_o | output | 2 | Pad output enable (bit 0 = A) |
| cnt_o | output | 8 | Current count |

## Verification
On every cycle, the assertions check the following local rules:
- the count, direction and waveform bits hold when no tick arrives;
- the single-slope count wraps to zero after TOP;
- a non-PWM toggle hit flips the bit;
- the single-slope BOTTOM action sets the bit in mode 10;
- an active compare value never moves in a PWM family except when the counter leaves TOP;
- a write block lasts one counting cycle.

Some behaviour only the bench scenarios can show. These are the full waveform across each family and mode pair, including the dual-slope direction swap and the compare-A-equals-TOP special cases. They also include the buffered compare load seen at the pads, and the single suppressed hit after a colliding write.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  // counting family, encoded as on wave_mode_i
  typedef enum logic [1:0] {
    FAM_FREE  = 2'b00,
    FAM_DUAL  = 2'b01,
    FAM_CLEAR = 2'b10,
    FAM_FAST  = 2'b11
  } fam_e;

  function automatic logic fam_is_pwm(fam_e f);
    return (f == FAM_DUAL) || (f == FAM_FAST);
  endfunction
endpackage

// File: rtl/tmr_wave_counter.sv
module tmr_wave_counter
  import tmr_wave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  fam_e         fam_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         step_up_o,
  output logic         at_top_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         step_up;

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = down_q;
    step_up = 1'b1;
    unique case (fam_i)
      FAM_DUAL: begin
        if (!down_q) begin
          if (cnt_q >= top_i) begin
            down_d  = 1'b1;
            cnt_d   = (cnt_q == '0) ? '0 : cnt_q - ONE;
            step_up = 1'b0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else if (cnt_q == '0) begin
          down_d = 1'b0;
          cnt_d  = (top_i == '0) ? '0 : ONE;
        end else begin
          cnt_d   = cnt_q - ONE;
          step_up = 1'b0;
        end
      end
      FAM_FREE: begin
        down_d = 1'b0;
        cnt_d  = cnt_q + ONE;
      end
      default: begin
        down_d = 1'b0;
        cnt_d  = (cnt_q == top_i) ? '0 : cnt_q + ONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = tick_i ? cnt_d : cnt_q;
  assign step_up_o = step_up;
  assign at_top_o  = (cnt_q == top_i);

  a_r12_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(down_q)));

  a_r3_fast_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fam_i == FAM_FAST && cnt_q == top_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_wave_cmp.sv
module tmr_wave_cmp #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pwm_i,
  input  logic         tick_i,
  input  logic         at_top_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  output logic [W-1:0] act_o,
  output logic         hit_o
);
  logic [W-1:0] hold_q, hold_d, act_q, act_d;
  logic         blk_q, blk_d;

  always_comb begin
    hold_d = we_i ? wdata_i : hold_q;
    act_d  = act_q;
    if (!pwm_i) begin
      if (we_i) act_d = wdata_i;
    end else if (tick_i && at_top_i) begin
      act_d = hold_d;
    end
    if (we_i && wdata_i == cnt_nxt_i) blk_d = 1'b1;
    else if (tick_i)                  blk_d = 1'b0;
    else                              blk_d = blk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
      blk_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
      blk_q  <= blk_d;
    end
  end

  assign act_o = act_q;
  assign hit_o = tick_i && (cnt_i == act_q) && !blk_q;

  a_r10_pwm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !(tick_i && at_top_i)) |=> $stable(act_q));

  a_r11_blk_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(we_i && wdata_i == cnt_nxt_i)) |=> !blk_q);
endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_wave_pkg::*;
#(
  parameter bit IS_A = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  fam_e       fam_i,
  input  logic [1:0] mode_i,
  input  logic       alt_tog_i,
  input  logic       hit_i,
  input  logic       at_top_i,
  input  logic       step_up_i,
  input  logic       a_eq_top_i,
  input  logic       port_i,
  input  logic       dir_i,
  output logic       pad_o,
  output logic       pad_oe_o
);
  logic wave_q, wave_d;
  logic pwm, special, alt_ok, conn;

  assign pwm     = fam_is_pwm(fam_i);
  assign alt_ok  = IS_A && alt_tog_i;
  assign special = IS_A && pwm && mode_i[1] && a_eq_top_i;
  assign conn    = (mode_i != 2'b00) && !(pwm && mode_i == 2'b01 && !alt_ok);

  always_comb begin
    wave_d = wave_q;
    if (tick_i) begin
      if (!pwm) begin
        if (hit_i) begin
          unique case (mode_i)
            2'b01:   wave_d = ~wave_q;
            2'b10:   wave_d = 1'b0;
            2'b11:   wave_d = 1'b1;
            default: wave_d = wave_q;
          endcase
        end
      end else if (mode_i[1]) begin
        if (fam_i == FAM_FAST) begin
          if (hit_i && !special) wave_d = mode_i[0];
          if (at_top_i)          wave_d = ~mode_i[0];
        end else if (special) begin
          if (at_top_i) wave_d = ~mode_i[0];
        end else if (hit_i) begin
          wave_d = step_up_i ? mode_i[0] : ~mode_i[0];
        end
      end else if (mode_i[0] && alt_ok && hit_i) begin
        wave_d = ~wave_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign pad_o    = conn ? wave_q : port_i;
  assign pad_oe_o = dir_i;

  a_r12_wave_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(wave_q));

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pwm && mode_i == 2'b01 && hit_i) |=> (wave_q != $past(wave_q)));

  a_r5_bottom_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fam_i == FAM_FAST && mode_i == 2'b10 && at_top_i) |=> wave_q);
endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_wave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   wave_mode_i,
  input  logic         top_sel_i,
  input  logic         cmp_a_we_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         cmp_b_we_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic [1:0]   out_mode_a_i,
  input  logic [1:0]   out_mode_b_i,
  input  logic [1:0]   dir_i,
  input  logic [1:0]   port_i,
  output logic [1:0]   pad_o,
  output logic [1:0]   pad_oe_o,
  output logic [W-1:0] cnt_o
);
  localparam int           NCH = 2;
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [1:0]   rst_sync_q;
  logic         rst_n;
  fam_e         fam;
  logic         pwm;
  logic [W-1:0] top, cnt, cnt_nxt;
  logic         step_up, at_top;
  logic [W-1:0] act   [NCH];
  logic [NCH-1:0] hit, we;
  logic [W-1:0] wdata [NCH];
  logic [1:0]   mode  [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign fam = fam_e'(wave_mode_i);
  assign pwm = fam_is_pwm(fam);
  assign top = (fam == FAM_CLEAR || (pwm && top_sel_i)) ? act[0] : MAX;

  assign we[0] = cmp_a_we_i;
  assign we[1] = cmp_b_we_i;
  assign wdata[0] = cmp_a_i;
  assign wdata[1] = cmp_b_i;
  assign mode[0] = out_mode_a_i;
  assign mode[1] = out_mode_b_i;

  tmr_wave_counter #(.W(W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick_i),
    .fam_i     (fam),
    .top_i     (top),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .step_up_o (step_up),
    .at_top_o  (at_top)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_wave_cmp #(.W(W)) i_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .pwm_i     (pwm),
      .tick_i    (tick_i),
      .at_top_i  (at_top),
      .we_i      (we[g]),
      .wdata_i   (wdata[g]),
      .cnt_i     (cnt),
      .cnt_nxt_i (cnt_nxt),
      .act_o     (act[g]),
      .hit_o     (hit[g])
    );

    tmr_wave_chan #(.IS_A(g == 0)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .tick_i     (tick_i),
      .fam_i      (fam),
      .mode_i     (mode[g]),
      .alt_tog_i  (top_sel_i),
      .hit_i      (hit[g]),
      .at_top_i   (at_top),
      .step_up_i  (step_up),
      .a_eq_top_i (act[0] == top),
      .port_i     (port_i[g]),
      .dir_i      (dir_i[g]),
      .pad_o      (pad_o[g]),
      .pad_oe_o   (pad_oe_o[g])
    );
  end

  assign cnt_o = cnt;
endmodule

// File: tb/test_tmr_wave_unit.sv
module test_tmr_wave_unit;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [1:0] wmode;
  logic       tsel;
  logic       we_a, we_b;
  logic [7:0] wa, wb;
  logic [1:0] ma, mb;
  logic [1:0] dir, port;
  logic [1:0] pad, pad_oe;
  logic [7:0] cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cnt;
  logic       m_down;
  logic [7:0] m_hold [2];
  logic [7:0] m_act  [2];
  logic       m_blk  [2];
  logic       m_wave [2];
  string      cur_tag;

  always #(PERIOD/2) clk = ~clk;

  tmr_wave_unit i_tmr_wave_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wave_mode_i(wmode),
    .top_sel_i(tsel), .cmp_a_we_i(we_a), .cmp_a_i(wa), .cmp_b_we_i(we_b),
    .cmp_b_i(wb), .out_mode_a_i(ma), .out_mode_b_i(mb), .dir_i(dir),
    .port_i(port), .pad_o(pad), .pad_oe_o(pad_oe), .cnt_o(cnt)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic exp_pad(int c);
    logic [1:0] md;
    logic pwm, conn;
    md   = (c == 0) ? ma : mb;
    pwm  = (wmode == 2'b01) || (wmode == 2'b11);
    conn = (md != 2'b00) && !(pwm && md == 2'b01 && !(c == 0 && tsel));
    return conn ? m_wave[c] : port[c];
  endfunction

  task automatic model_step();
    logic pwm, atop, sup, ndown, ah;
    logic [7:0] top, ncnt, wd, nh;
    logic [1:0] md;
    logic hit [2];
    logic nw  [2];
    logic wen;
    pwm  = (wmode == 2'b01) || (wmode == 2'b11);
    top  = (wmode == 2'b10 || (pwm && tsel)) ? m_act[0] : 8'hFF;
    atop = (m_cnt == top);
    for (int c = 0; c < 2; c++) hit[c] = tick && m_cnt == m_act[c] && !m_blk[c];
    sup = 1'b1; ndown = 1'b0; ncnt = m_cnt + 8'd1;
    if (wmode == 2'b01) begin
      if (!m_down && m_cnt >= top) begin
        ndown = 1'b1; sup = 1'b0; ncnt = (m_cnt == 0) ? 8'd0 : m_cnt - 8'd1;
      end else if (!m_down) begin
        ncnt = m_cnt + 8'd1;
      end else if (m_cnt == 0) begin
        ndown = 1'b0; ncnt = (top == 0) ? 8'd0 : 8'd1;
      end else begin
        ndown = 1'b1; sup = 1'b0; ncnt = m_cnt - 8'd1;
      end
    end else if (wmode != 2'b00) begin
      ncnt = atop ? 8'd0 : m_cnt + 8'd1;
    end
    for (int c = 0; c < 2; c++) begin
      md = (c == 0) ? ma : mb;
      ah = (c == 0) && pwm && md[1] && (m_act[0] == top);
      nw[c] = m_wave[c];
      if (tick) begin
        if (!pwm) begin
          if (hit[c] && md == 2'b01) nw[c] = ~m_wave[c];
          if (hit[c] && md == 2'b10) nw[c] = 1'b0;
          if (hit[c] && md == 2'b11) nw[c] = 1'b1;
        end else if (md[1] && wmode == 2'b11) begin
          if (hit[c] && !ah) nw[c] = md[0];
          if (atop) nw[c] = ~md[0];
        end else if (md[1]) begin
          if (ah) begin
            if (atop) nw[c] = ~md[0];
          end else if (hit[c]) nw[c] = sup ? md[0] : ~md[0];
        end else if (md == 2'b01 && c == 0 && tsel && hit[c]) begin
          nw[c] = ~m_wave[c];
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      wen = (c == 0) ? we_a : we_b;
      wd  = (c == 0) ? wa : wb;
      nh  = wen ? wd : m_hold[c];
      if (!pwm) begin
        if (wen) m_act[c] = wd;
      end else if (tick && atop) m_act[c] = nh;
      m_hold[c] = nh;
      if (wen && wd == (tick ? ncnt : m_cnt)) m_blk[c] = 1'b1;
      else if (tick) m_blk[c] = 1'b0;
      m_wave[c] = nw[c];
    end
    if (tick) begin
      m_cnt  = ncnt;
      m_down = ndown;
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk); #1;
    we_a = 1'b0; we_b = 1'b0;
    chk("R3 count", cnt, m_cnt);
    chk({cur_tag, " pad A"}, 8'(pad[0]), 8'(exp_pad(0)));
    chk({cur_tag, " pad B"}, 8'(pad[1]), 8'(exp_pad(1)));
    chk("R2 oe", 8'(pad_oe), 8'(dir));
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic do_reset();
    tick = 0; we_a = 0; we_b = 0;
    @(posedge clk); #1;
    rst_n = 0;
    m_cnt = 0; m_down = 0;
    for (int c = 0; c < 2; c++) begin
      m_hold[c] = 0; m_act[c] = 0; m_blk[c] = 0; m_wave[c] = 0;
    end
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1;
    run(3);
  endtask

  task automatic wr(int c, logic [7:0] v);
    if (c == 0) begin we_a = 1; wa = v; end
    else        begin we_b = 1; wb = v; end
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; wmode = 0; tsel = 0; we_a = 0; we_b = 0;
    wa = 0; wb = 0; ma = 0; mb = 0; dir = 2'b11; port = 2'b10;
    cur_tag = "R1";
    do_reset();
    // R1: reset state
    chk("R1 count", cnt, 8'd0);
    chk("R1 pads show port", 8'(pad), 8'(2'b10));
    dir = 2'b01; #1;
    chk("R2 oe follows dir", 8'(pad_oe), 8'(2'b01));
    dir = 2'b11;

    // R12: no tick, nothing moves
    cur_tag = "R12"; wmode = 2'b00; ma = 2'b11; mb = 2'b01;
    tick = 1; run(6);
    tick = 0; run(5);
    chk("R12 count held", cnt, 8'd6);

    // R11: colliding write blocks one hit (free-running, toggle)
    cur_tag = "R11"; ma = 2'b01; mb = 2'b00;
    do_reset();
    tick = 1; run(4);            // hit at 0 toggles A to 1
    tick = 0; wr(0, 8'd4); run(1);
    tick = 1; run(1);            // hit at 4 blocked
    chk("R11 blocked hit", 8'(pad[0]), 8'd1);
    chk("R11 count", cnt, 8'd5);
    run(256);                    // next hit at 4 toggles
    chk("R11 later hit toggles", 8'(pad[0]), 8'd0);

    // R10: buffered compare in single-slope
    cur_tag = "R10"; wmode = 2'b11; tsel = 0; ma = 2'b00; mb = 2'b10;
    do_reset();
    wr(1, 8'd5); run(1);
    tick = 1; run(256);
    chk("R10 wrap sets B", 8'(pad[1]), 8'd1);
    run(2);
    tick = 0; wr(1, 8'd100); run(1);
    tick = 1; run(4);
    chk("R10 old compare still active", 8'(pad[1]), 8'd0);
    chk("R10 count", cnt, 8'd6);

    // R7: channel B mode 01 reserved in PWM
    cur_tag = "R7"; mb = 2'b01; port = 2'b00; run(3);
    chk("R7 B shows port", 8'(pad[1]), 8'd0);
    port = 2'b10; #1;
    chk("R7 B shows port", 8'(pad[1]), 8'd1);

    // R8: single-slope, A at TOP
    cur_tag = "R8"; tsel = 1; ma = 2'b10; mb = 2'b00;
    do_reset();
    tick = 0; wr(0, 8'd9); run(1);
    tick = 1; run(25);
    chk("R8 A set at bottom", 8'(pad[0]), 8'd1);

    // R9: dual-slope, A at TOP
    cur_tag = "R9"; wmode = 2'b01; tsel = 1; ma = 2'b10;
    do_reset();
    tick = 0; wr(0, 8'd9); run(1);
    tick = 1; run(30);
    chk("R9 A set at top", 8'(pad[0]), 8'd1);
    ma = 2'b11; run(20);
    chk("R9 A cleared at top", 8'(pad[0]), 8'd0);

    // sweep over families, TOP select and both mode fields
    for (int f = 0; f < 4; f++)
      for (int ts = 0; ts < 2; ts++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            logic big;
            int   n;
            wmode = 2'(f); tsel = ts[0]; ma = 2'(a); mb = 2'(b);
            cur_tag = (f == 1) ? "R6" : (f == 3) ? "R5" : "R4";
            big = (f == 0) || (f != 2 && ts == 0);
            do_reset();
            tick = 0; wr(0, big ? 8'd100 : 8'd9); wr(1, big ? 8'd60 : 8'd5); run(1);
            n = big ? 560 : 60;
            for (int k = 0; k < n; k++) begin
              tick = (k % 7) != 3;
              port = 2'(k);
              if (k == 30) wr(1, big ? 8'd62 : 8'd7);
              cycle();
            end
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule